// File: doc/BRIEF.md
# Write-Back Write-Allocate Byte Cache

This block is a small, fully associative data cache that sits between a processor byte port and a byte-wide memory port. Every line holds a valid flag, a dirty flag, a tag and a block of bytes. Stores that hit only change the cached copy and mark the line dirty, so store hits cause no memory traffic. Any miss, load or store, allocates a line. If the chosen victim is dirty, its whole block is first written back to memory one byte at a time. The new block is then fetched in full. A victim that is valid but clean is only invalidated.

The replacement choice is least-recently-used among valid lines, and an invalid line is always taken first. A flush request walks all lines in index order, writes back every valid dirty line and leaves the lines valid and clean. A single-cycle done pulse ends the walk. Two counters report processor hits and misses.

The controller is one state machine with these states. `ST_IDLE` looks up requests. `ST_EVICT` writes the victim back, one byte per memory handshake. `ST_FILL` reads the new block, one byte per handshake. `ST_FINISH` installs the line and acknowledges the processor. `ST_FL_SCAN` checks the line under the flush pointer. `ST_FL_WB` writes one flushed line back. `ST_FL_DONE` signals the end of a flush.

The transitions are:
- IDLE→IDLE on a hit.
- IDLE→EVICT on a miss with a dirty victim.
- IDLE→FILL on a miss with an invalid or clean victim.
- EVICT→FILL after the last byte is written.
- FILL→FINISH after the last byte is read.
- FINISH→IDLE.
- IDLE→FL_SCAN on a flush request when no processor request is pending.
- FL_SCAN→FL_WB for a dirty line.
- FL_SCAN→FL_SCAN to step to the next line.
- FL_SCAN→FL_DONE after the last line.
- FL_WB→FL_SCAN or FL_DONE after the last byte.
- FL_DONE→IDLE.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is invalid, both counters read zero, and cpu_ack, flush_done and mem_req are low.
- R2: A load that hits asserts cpu_ack in the same cycle it is presented, returns the cached byte and starts no memory request.
- R3: A store that hits writes the byte into the cached block, marks the line dirty, acknowledges in the same cycle and sends nothing to memory.
- R4: A miss whose victim is invalid or clean reads the whole block from memory, in ascending offset order, with no memory write.
- R5: A miss whose victim is dirty first writes all bytes of the victim block back, to the victim's tag and in ascending offset order. The fill reads start only after that.
- R6: A store miss completes by merging the store byte into the freshly fetched block and marking the line dirty. The other bytes keep their fetched values.
- R7: The victim is the lowest-index invalid line if one exists. Otherwise it is the least recently used line, where every hit and every completed miss makes its line the most recently used.
- R8: hit_count increments once per hit, and miss_count increments once per miss.
- R9: A flush writes back every valid dirty line and leaves all lines valid and clean. It then raises flush_done for exactly one cycle. A flush with no dirty line writes nothing.
- R10: At most one memory request is outstanding. Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until mem_ack.
- R11: A byte address splits into a tag (the upper ADDR_W-OFF_W bits) and a block offset (the low OFF_W bits). Memory addresses are formed as {tag, offset}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ack | output | 1 | Single-cycle completion |
| cpu_rdata | output | 8 | Load byte, valid with cpu_ack |
| flush_req | input | 1 | Start a flush walk (sampled in idle) |
| flush_done | output | 1 | Single-cycle end-of-flush pulse |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write-back byte |
| mem_ack | input | 1 | Single-cycle memory completion |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
Some properties are checked on every cycle:
- The memory request is held stable until its acknowledge.
- The fill never starts while the victim is still valid or dirty.
- A store hit leaves its line dirty.
- No two lines hold the same valid tag.
- The LRU ages always form a permutation.
- flush_done is a single-cycle pulse, and the miss counter never jumps.

Other behaviours need the bench's directed sequences:
- which line LRU actually picks,
- the byte values and order of write-back and fill traffic,
- the merge of a store miss into fetched data,
- that data written back is later read again,
- that flush leaves lines valid and clean.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_FINISH,
        ST_FL_SCAN,
        ST_FL_WB,
        ST_FL_DONE
    } wbc_state_e;

    // Line-store commands, one per cycle
    typedef enum logic [2:0] {
        LOP_NONE,
        LOP_STORE,
        LOP_FILL,
        LOP_DROP,
        LOP_CLEAN,
        LOP_INSTALL
    } wbc_lop_e;

endpackage

// File: rtl/wbc_lines.sv
module wbc_lines
    import wbc_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int OFF_W = 1,
    parameter int LINES = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wbc_lop_e         lop,
    input  logic [IDX_W-1:0] lidx,
    input  logic [OFF_W-1:0] loff,
    input  logic [7:0]       lbyte,
    input  logic [TAG_W-1:0] ltag,
    input  logic             ldirty,
    input  logic [TAG_W-1:0] look_tag,
    input  logic [OFF_W-1:0] a_off,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [7:0]       a_byte,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [OFF_W-1:0] b_off,
    output logic [7:0]       b_byte,
    output logic [TAG_W-1:0] b_tag,
    output logic [LINES-1:0] valid_o,
    output logic [LINES-1:0] dirty_o
);

    localparam int BLK = 1 << OFF_W;

    logic [LINES-1:0] valid_q, dirty_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [7:0]       data_q [LINES][BLK];
    logic [LINES-1:0] match;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (tag_q[g] == look_tag);
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit     = |match;
    assign a_byte  = data_q[hit_idx][a_off];
    assign b_byte  = data_q[b_idx][b_off];
    assign b_tag   = tag_q[b_idx];
    assign valid_o = valid_q;
    assign dirty_o = dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                for (int j = 0; j < BLK; j++) data_q[i][j] <= '0;
            end
        end else begin
            unique case (lop)
                LOP_STORE: begin
                    data_q[lidx][loff] <= lbyte;
                    dirty_q[lidx]      <= 1'b1;
                end
                LOP_FILL: data_q[lidx][loff] <= lbyte;
                LOP_DROP: begin
                    valid_q[lidx] <= 1'b0;
                    dirty_q[lidx] <= 1'b0;
                end
                LOP_CLEAN: dirty_q[lidx] <= 1'b0;
                LOP_INSTALL: begin
                    valid_q[lidx] <= 1'b1;
                    tag_q[lidx]   <= ltag;
                    dirty_q[lidx] <= ldirty;
                    if (ldirty) data_q[lidx][loff] <= lbyte;
                end
                default: ;
            endcase
        end
    end

    assert_store_marks_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lop == LOP_STORE) |=> dirty_q[$past(lidx)]);

    assert_victim_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lop == LOP_DROP) |=> (!valid_q[$past(lidx)] && !dirty_q[$past(lidx)]));

    assert_unique_tags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
    parameter int LINES = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [LINES-1:0] valid_i,
    output logic [IDX_W-1:0] victim
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

    logic [IDX_W-1:0] age_q [LINES];
    logic             found;
    logic [LINES-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(LINES - 1 - i);
        end else if (touch) begin
            for (int i = 0; i < LINES; i++) begin
                if (IDX_W'(i) == touch_idx)            age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])  age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (!found && !valid_i[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (age_q[i] == OLDEST) victim = IDX_W'(i);
            end
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < LINES; i++) seen[age_q[i]] = 1'b1;
    end

    assert_age_permutation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == LINES);

endmodule

// File: rtl/wbc_seq.sv
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int OFF_W  = 1,
    parameter int LINES  = 2,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ack,
    output logic [7:0]        cpu_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  hit_idx_i,
    input  logic [7:0]        a_byte_i,
    input  logic [IDX_W-1:0]  victim_i,
    input  logic [LINES-1:0]  valid_i,
    input  logic [LINES-1:0]  dirty_i,
    input  logic [7:0]        b_byte_i,
    input  logic [ADDR_W-OFF_W-1:0] b_tag_i,
    output logic [IDX_W-1:0]  b_idx,
    output logic [OFF_W-1:0]  b_off,
    output wbc_lop_e          lop,
    output logic [IDX_W-1:0]  lidx,
    output logic [OFF_W-1:0]  loff,
    output logic [7:0]        lbyte,
    output logic [ADDR_W-OFF_W-1:0] ltag,
    output logic              ldirty,
    output logic              touch,
    output logic [IDX_W-1:0]  touch_idx,
    output logic              hit_evt,
    output logic              miss_evt
);

    localparam int TAG_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] WORD_LAST = '1;
    localparam logic [IDX_W-1:0] LINE_LAST = IDX_W'(LINES - 1);

    wbc_state_e       state_q, state_d;
    logic [OFF_W-1:0] word_q, word_d;
    logic [IDX_W-1:0] vic_q, vic_d;
    logic [IDX_W-1:0] fl_q, fl_d;
    logic [TAG_W-1:0] rq_tag_q;
    logic [OFF_W-1:0] rq_off_q;
    logic             rq_we_q;
    logic [7:0]       rq_byte_q;
    logic             cap_req;

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            word_q    <= '0;
            vic_q     <= '0;
            fl_q      <= '0;
            rq_tag_q  <= '0;
            rq_off_q  <= '0;
            rq_we_q   <= 1'b0;
            rq_byte_q <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            vic_q   <= vic_d;
            fl_q    <= fl_d;
            if (cap_req) begin
                rq_tag_q  <= cpu_addr[ADDR_W-1:OFF_W];
                rq_off_q  <= cpu_addr[OFF_W-1:0];
                rq_we_q   <= cpu_we;
                rq_byte_q <= cpu_wdata;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        word_d     = word_q;
        vic_d      = vic_q;
        fl_d       = fl_q;
        cap_req    = 1'b0;
        cpu_ack    = 1'b0;
        cpu_rdata  = '0;
        flush_done = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        b_idx      = vic_q;
        b_off      = word_q;
        lop        = LOP_NONE;
        lidx       = vic_q;
        loff       = word_q;
        lbyte      = '0;
        ltag       = rq_tag_q;
        ldirty     = 1'b0;
        touch      = 1'b0;
        touch_idx  = vic_q;
        hit_evt    = 1'b0;
        miss_evt   = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit_i) begin
                        cpu_ack   = 1'b1;
                        cpu_rdata = a_byte_i;
                        touch     = 1'b1;
                        touch_idx = hit_idx_i;
                        hit_evt   = 1'b1;
                        if (cpu_we) begin
                            lop   = LOP_STORE;
                            lidx  = hit_idx_i;
                            loff  = cpu_addr[OFF_W-1:0];
                            lbyte = cpu_wdata;
                        end
                    end else begin
                        miss_evt = 1'b1;
                        cap_req  = 1'b1;
                        vic_d    = victim_i;
                        word_d   = '0;
                        if (valid_i[victim_i] && dirty_i[victim_i]) begin
                            state_d = ST_EVICT;
                        end else begin
                            lop     = LOP_DROP;
                            lidx    = victim_i;
                            state_d = ST_FILL;
                        end
                    end
                end else if (flush_req) begin
                    fl_d    = '0;
                    state_d = ST_FL_SCAN;
                end
            end

            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {b_tag_i, word_q};
                mem_wdata = b_byte_i;
                if (mem_ack) begin
                    if (word_q == WORD_LAST) begin
                        lop     = LOP_DROP;
                        word_d  = '0;
                        state_d = ST_FILL;
                    end else begin
                        word_d = word_q + 1'b1;
                    end
                end
            end

            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {rq_tag_q, word_q};
                if (mem_ack) begin
                    lop   = LOP_FILL;
                    lbyte = mem_rdata;
                    if (word_q == WORD_LAST) state_d = ST_FINISH;
                    else                     word_d  = word_q + 1'b1;
                end
            end

            ST_FINISH: begin
                cpu_ack = 1'b1;
                b_off   = rq_off_q;
                cpu_rdata = rq_we_q ? rq_byte_q : b_byte_i;
                lop     = LOP_INSTALL;
                loff    = rq_off_q;
                lbyte   = rq_byte_q;
                ldirty  = rq_we_q;
                touch   = 1'b1;
                state_d = ST_IDLE;
            end

            ST_FL_SCAN: begin
                if (valid_i[fl_q] && dirty_i[fl_q]) begin
                    word_d  = '0;
                    state_d = ST_FL_WB;
                end else if (fl_q == LINE_LAST) begin
                    state_d = ST_FL_DONE;
                end else begin
                    fl_d = fl_q + 1'b1;
                end
            end

            ST_FL_WB: begin
                b_idx     = fl_q;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {b_tag_i, word_q};
                mem_wdata = b_byte_i;
                if (mem_ack) begin
                    if (word_q == WORD_LAST) begin
                        lop  = LOP_CLEAN;
                        lidx = fl_q;
                        if (fl_q == LINE_LAST) begin
                            state_d = ST_FL_DONE;
                        end else begin
                            fl_d    = fl_q + 1'b1;
                            state_d = ST_FL_SCAN;
                        end
                    end else begin
                        word_d = word_q + 1'b1;
                    end
                end
            end

            ST_FL_DONE: begin
                flush_done = 1'b1;
                state_d    = ST_IDLE;
            end

            default: state_d = ST_IDLE;
        endcase
    end

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req);

    assert_fill_after_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (!valid_i[vic_q] && !dirty_i[vic_q]));

    assert_flush_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

endmodule

// File: rtl/wb_cache.sv
module wb_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int OFF_W  = 1,
    parameter int LINES  = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ack,
    output logic [7:0]        cpu_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    wbc_lop_e         lop;
    logic [IDX_W-1:0] lidx, hit_idx, b_idx, victim, touch_idx;
    logic [OFF_W-1:0] loff, b_off;
    logic [7:0]       lbyte, a_byte, b_byte;
    logic [TAG_W-1:0] ltag, b_tag;
    logic             ldirty, hit, touch, hit_evt, miss_evt;
    logic [LINES-1:0] valid_v, dirty_v;
    logic [CNT_W-1:0] hit_q, miss_q;

    wbc_lines #(.TAG_W(TAG_W), .OFF_W(OFF_W), .LINES(LINES), .IDX_W(IDX_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .lop(lop), .lidx(lidx), .loff(loff), .lbyte(lbyte), .ltag(ltag), .ldirty(ldirty),
        .look_tag(cpu_addr[ADDR_W-1:OFF_W]), .a_off(cpu_addr[OFF_W-1:0]),
        .hit(hit), .hit_idx(hit_idx), .a_byte(a_byte),
        .b_idx(b_idx), .b_off(b_off), .b_byte(b_byte), .b_tag(b_tag),
        .valid_o(valid_v), .dirty_o(dirty_v)
    );

    wbc_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch(touch), .touch_idx(touch_idx),
        .valid_i(valid_v), .victim(victim)
    );

    wbc_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINES(LINES), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .flush_req(flush_req), .flush_done(flush_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_i(hit), .hit_idx_i(hit_idx), .a_byte_i(a_byte),
        .victim_i(victim), .valid_i(valid_v), .dirty_i(dirty_v),
        .b_byte_i(b_byte), .b_tag_i(b_tag), .b_idx(b_idx), .b_off(b_off),
        .lop(lop), .lidx(lidx), .loff(loff), .lbyte(lbyte), .ltag(ltag), .ldirty(ldirty),
        .touch(touch), .touch_idx(touch_idx),
        .hit_evt(hit_evt), .miss_evt(miss_evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= '0;
            miss_q <= '0;
        end else begin
            if (hit_evt)  hit_q  <= hit_q + 1'b1;
            if (miss_evt) miss_q <= miss_q + 1'b1;
        end
    end

    assign hit_count  = hit_q;
    assign miss_count = miss_q;

    assert_miss_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1));

    assert_hit_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + 1'b1));

endmodule

// File: tb/wb_cache_bench.sv
module wb_cache_bench;

    localparam int ADDR_W = 5;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_ack;
    logic [7:0]        cpu_rdata;
    logic              flush_req = 1'b0, flush_done;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_ack;
    logic [7:0]        mem_rdata;
    logic [CNT_W-1:0]  hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int exp_hits = 0;
    int exp_misses = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wb_cache u_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .flush_req(flush_req), .flush_done(flush_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [7:0] init_byte(input int a);
        return 8'(8'h10 + 8'(a) * 8'd7);
    endfunction

    // Memory model: two cycles of wait, one-cycle ack, event log
    logic [7:0]        mem [32];
    int                lat;
    int                ev_n;
    logic              ev_we   [64];
    logic [ADDR_W-1:0] ev_addr [64];
    logic [7:0]        ev_data [64];
    logic [ADDR_W-1:0] p_addr;
    logic              p_we;
    logic [7:0]        p_wd;
    bit                r10_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= init_byte(i);
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat       <= 0;
            ev_n      <= 0;
            r10_bad   <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat == 0) begin
                    p_addr <= mem_addr;
                    p_we   <= mem_we;
                    p_wd   <= mem_wdata;
                    lat    <= 1;
                end else begin
                    if (mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd) r10_bad <= 1'b1;
                    if (lat == 2) begin
                        mem_ack <= 1'b1;
                        if (mem_we) mem[mem_addr] <= mem_wdata;
                        else        mem_rdata <= mem[mem_addr];
                        ev_we[ev_n[5:0]]   <= mem_we;
                        ev_addr[ev_n[5:0]] <= mem_addr;
                        ev_data[ev_n[5:0]] <= mem_we ? mem_wdata : mem[mem_addr];
                        ev_n <= ev_n + 1;
                        lat  <= 0;
                    end else begin
                        lat <= lat + 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input int a, input logic [7:0] wd,
                          output logic [7:0] rd, output int start);
        @(negedge clk);
        start     = ev_n;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = ADDR_W'(a);
        cpu_wdata = wd;
        forever begin
            #1;
            if (cpu_ack) begin
                rd = cpu_rdata;
                @(posedge clk);
                #1;
                cpu_req = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic chk_ev(input string req, input int idx, input bit we,
                          input int a, input int d);
        chk(ev_we[idx[5:0]] == we, req, "memory op kind", int'(ev_we[idx[5:0]]), int'(we));
        chk(ev_addr[idx[5:0]] == ADDR_W'(a), req, "memory address", int'(ev_addr[idx[5:0]]), a);
        chk(ev_data[idx[5:0]] == 8'(d), req, "memory byte", int'(ev_data[idx[5:0]]), d);
    endtask

    task automatic do_flush(output int start);
        int waited;
        @(negedge clk);
        start     = ev_n;
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        waited = 0;
        while (!flush_done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk(flush_done == 1'b1, "R9", "flush_done seen", int'(flush_done), 1);
        @(negedge clk);
        chk(flush_done == 1'b0, "R9", "flush_done single cycle", int'(flush_done), 0);
    endtask

    task automatic t_reset;
        chk(cpu_ack == 1'b0, "R1", "cpu_ack after reset", int'(cpu_ack), 0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
        chk(flush_done == 1'b0, "R1", "flush_done after reset", int'(flush_done), 0);
        chk(hit_count == 0, "R1", "hit_count after reset", int'(hit_count), 0);
        chk(miss_count == 0, "R1", "miss_count after reset", int'(miss_count), 0);
    endtask

    task automatic t_cold_loads;
        logic [7:0] rd; int s;
        // R1 R4 R11: addr 1 -> tag 0, reads 0 then 1
        access(1'b0, 1, 8'h00, rd, s); exp_misses++;
        chk(rd == init_byte(1), "R4", "cold load data", int'(rd), int'(init_byte(1)));
        chk(ev_n - s == 2, "R4", "cold fill read count", ev_n - s, 2);
        chk_ev("R11", s, 1'b0, 0, init_byte(0));
        chk_ev("R11", s + 1, 1'b0, 1, init_byte(1));
        access(1'b0, 7, 8'h00, rd, s); exp_misses++;
        chk(rd == init_byte(7), "R4", "second cold load data", int'(rd), int'(init_byte(7)));
        chk_ev("R4", s, 1'b0, 6, init_byte(6));
        chk_ev("R4", s + 1, 1'b0, 7, init_byte(7));
        chk(miss_count == 2, "R8", "miss count after cold loads", int'(miss_count), 2);
    endtask

    task automatic t_hits;
        logic [7:0] rd; int s;
        access(1'b1, 0, 8'hA5, rd, s); exp_hits++;
        chk(ev_n - s == 0, "R3", "store hit memory traffic", ev_n - s, 0);
        chk(mem[0] == init_byte(0), "R3", "memory untouched by store hit", int'(mem[0]), int'(init_byte(0)));
        access(1'b0, 0, 8'h00, rd, s); exp_hits++;
        chk(rd == 8'hA5, "R2", "load hit returns stored byte", int'(rd), 8'hA5);
        chk(ev_n - s == 0, "R2", "load hit memory traffic", ev_n - s, 0);
        chk(hit_count == 2, "R8", "hit count", int'(hit_count), 2);
    endtask

    task automatic t_clean_victim;
        logic [7:0] rd; int s;
        // LRU is the tag-3 line (clean): no write-back
        access(1'b1, 5, 8'h3C, rd, s); exp_misses++;
        chk(ev_n - s == 2, "R4", "clean victim event count", ev_n - s, 2);
        chk_ev("R7", s, 1'b0, 4, init_byte(4));
        chk_ev("R4", s + 1, 1'b0, 5, init_byte(5));
    endtask

    task automatic t_dirty_victim;
        logic [7:0] rd; int s;
        // LRU is the dirty tag-0 line: both bytes written back first
        access(1'b0, 10, 8'h00, rd, s); exp_misses++;
        chk(ev_n - s == 4, "R5", "dirty victim event count", ev_n - s, 4);
        chk_ev("R5", s, 1'b1, 0, 8'hA5);
        chk_ev("R5", s + 1, 1'b1, 1, init_byte(1));
        chk_ev("R5", s + 2, 1'b0, 10, init_byte(10));
        chk_ev("R5", s + 3, 1'b0, 11, init_byte(11));
        chk(rd == init_byte(10), "R5", "load data after write-back", int'(rd), int'(init_byte(10)));
    endtask

    task automatic t_merge;
        logic [7:0] rd; int s;
        access(1'b0, 4, 8'h00, rd, s); exp_hits++;
        chk(rd == init_byte(4), "R6", "fetched neighbour byte kept", int'(rd), int'(init_byte(4)));
        access(1'b0, 5, 8'h00, rd, s); exp_hits++;
        chk(rd == 8'h3C, "R6", "store-miss byte merged", int'(rd), 8'h3C);
        chk(ev_n - s == 0, "R6", "merged line hits", ev_n - s, 0);
    endtask

    task automatic t_reload_written_back;
        logic [7:0] rd; int s;
        // LRU is the clean tag-5 line; the written-back byte returns from memory
        access(1'b0, 0, 8'h00, rd, s); exp_misses++;
        chk(rd == 8'hA5, "R5", "written-back byte reloaded", int'(rd), 8'hA5);
        chk(ev_n - s == 2, "R7", "clean LRU victim no write", ev_n - s, 2);
    endtask

    task automatic t_flush;
        logic [7:0] rd; int s;
        do_flush(s);
        chk(ev_n - s == 2, "R9", "flush write count", ev_n - s, 2);
        chk_ev("R9", s, 1'b1, 4, init_byte(4));
        chk_ev("R9", s + 1, 1'b1, 5, 8'h3C);
        do_flush(s);
        chk(ev_n - s == 0, "R9", "second flush writes nothing", ev_n - s, 0);
        access(1'b0, 5, 8'h00, rd, s); exp_hits++;
        chk(rd == 8'h3C && ev_n - s == 0, "R9", "line valid after flush", int'(rd), 8'h3C);
    endtask

    task automatic t_store_miss_chain;
        logic [7:0] rd; int s;
        access(1'b1, 12, 8'h77, rd, s); exp_misses++;
        chk(ev_n - s == 2, "R6", "store miss fill only", ev_n - s, 2);
        access(1'b1, 13, 8'h88, rd, s); exp_hits++;
        chk(ev_n - s == 0, "R3", "store hit after store miss", ev_n - s, 0);
        access(1'b0, 20, 8'h00, rd, s); exp_misses++;
        chk(ev_n - s == 2, "R7", "flushed line evicted clean", ev_n - s, 2);
        chk(rd == init_byte(20), "R4", "load 20 data", int'(rd), int'(init_byte(20)));
        access(1'b0, 24, 8'h00, rd, s); exp_misses++;
        chk(ev_n - s == 4, "R6", "store-miss line written back", ev_n - s, 4);
        chk_ev("R6", s, 1'b1, 12, 8'h77);
        chk_ev("R6", s + 1, 1'b1, 13, 8'h88);
        chk_ev("R5", s + 2, 1'b0, 24, init_byte(24));
    endtask

    task automatic t_counters;
        chk(int'(hit_count) == exp_hits, "R8", "final hit count", int'(hit_count), exp_hits);
        chk(int'(miss_count) == exp_misses, "R8", "final miss count", int'(miss_count), exp_misses);
        chk(r10_bad == 1'b0, "R10", "request stable until ack", int'(r10_bad), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cold_loads;
        t_hits;
        t_clean_victim;
        t_dirty_victim;
        t_merge;
        t_reload_written_back;
        t_flush;
        t_store_miss_chain;
        t_counters;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

endmodule